// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Back-to-Back Read/Write

This block is a synthesizable model of a synchronous static RAM that accepts a read or a write on every clock. No idle cycle is needed when the bus turns from reads to writes. The rising clock edge captures every control and address input. Write data arrives late, in the same bus slot where read data would appear. In pipelined mode that slot is two edges after the address. In flow-through mode it is one edge after. Because of this, the data bus is used in every cycle, whatever mix of reads and writes the system issues.

Each access is either a single word or a four-beat burst. A load cycle starts the access, and advance cycles continue it. Burst beats wrap inside the low two address bits. A static input picks linear or interleaved beat order. Three chip-select inputs must all be active for a load to start an access. This lets several devices share one address bus for depth expansion. The output enable and the sleep input act without waiting for a clock and can turn the data outputs off at any time. While sleep is asserted, no new access starts, and the array keeps its contents.

The address and byte enables of each write stay in a short pipeline until the write data arrives. In pipelined mode, a read can reach the array while an older write to the same word is still waiting for its data. In that case the waiting bytes are taken from the write data bus, so the read returns the newest value.

The burst controller is a state machine with three states:

- `ST_IDLE`: no access is open.
- `ST_RD_BURST`: a read access is open.
- `ST_WR_BURST`: a write access is open.

Its transitions are:

- **load-read**: a selected load with the write request low goes to `ST_RD_BURST`.
- **load-write**: a selected load with the write request high goes to `ST_WR_BURST`.
- **deselect**: a load while any chip select is inactive goes to `ST_IDLE`.
- **sleep-abort**: sleep asserted goes to `ST_IDLE` from any state.
- **advance**: an advance cycle keeps the current state. In `ST_RD_BURST` or `ST_WR_BURST` it steps the beat count; in `ST_IDLE` it does nothing.

Top module: `lw_sram`

## Requirements
- R1: A load starts an access only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load with any of them inactive is a deselect: no data is driven in its bus slot, and a following advance does nothing.
- R2: In pipelined mode (`flow_mode`=0), the data for a read whose address is captured at edge N is driven, with `rdata_oe`=1, during the cycle after edge N+1.
- R3: In flow-through mode (`flow_mode`=1), the data for a read captured at edge N is driven during the cycle after edge N.
- R4: The data for a write captured at edge N is taken from `wdata` at edge N+2 in pipelined mode and at edge N+1 in flow-through mode.
- R5: Reads and writes may be issued on consecutive edges in any mix. Each one occupies exactly one bus slot, and every read returns the value left by all writes issued before it.
- R6: `be[i]`=1 lets a write change bits 9i+8..9i of the word. A byte whose enable is 0 keeps its old value.
- R7: With `ilv_order`=0, beat k of a burst (k=0..3) addresses the start address with its low two bits replaced by (start+k) mod 4. The upper bits stay the same for the whole burst.
- R8: With `ilv_order`=1, beat k addresses the start address with its low two bits replaced by (start XOR k).
- R9: In pipelined mode, a read of a word whose previous-cycle write is still waiting for data returns the newly written bytes merged with the old unwritten bytes.
- R10: While `oe`=0, `rdata_oe` is 0 and `rdata` is all zeros, within the same cycle, whatever read is in progress.
- R11: While `sleep`=1, loads and advances start nothing, `rdata_oe` is 0 and `rdata` is zero. Stored data is kept, and accesses work again once sleep is released.
- R12: While `rst_n`=0, and after reset until a read is issued, `rdata_oe` is 0 and `rdata` is zero. The burst controller starts in `ST_IDLE`.
- R13: An advance cycle in `ST_IDLE` starts no access and drives no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the control pipeline |
| flow_mode | input | 1 | Static: 0 pipelined reads with two-edge late write, 1 flow-through reads with one-edge late write |
| ilv_order | input | 1 | Static: 0 linear burst order, 1 interleaved burst order |
| addr | input | ADDR_W | Word address sampled on load cycles |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| ld | input | 1 | 1 starts a new access (or deselects), 0 advances the open burst |
| wr | input | 1 | On a load: 1 write access, 0 read access |
| be | input | NB | Byte write enables for the write beat captured on this edge |
| wdata | input | NB*BW | Late write data |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | NB*BW | Read data, zero while not driven |
| rdata_oe | output | 1 | High while rdata carries valid read data |

## Verification
If the address or byte-enable pipeline is wrong, the wrong word shows up on `rdata` in the very slot where the read is due. It appears one or two cycles after the faulty access was captured, so the bench compares every slot against an expected-value queue kept in program order. A wrong burst state or beat counter shows up as a wrong word on the second to fourth beat of a burst. It can also show up as data driven in a slot that should be empty, so the bench also checks every cycle where no read is due. A missing forward path is visible only when a read comes right after a write to the same word in pipelined mode, so that case is driven on purpose with partial byte enables.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_BURST = 2'd1,
        ST_WR_BURST = 2'd2
    } burst_st_e;

    // Low two address bits of a burst beat: XOR for interleaved, add for linear.
    function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       ilv);
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NB     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ilv_order,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              ld,
    input  logic              wr,
    input  logic [NB-1:0]     be,
    input  logic              sleep,
    output logic              s1_vld,
    output logic              s1_wr,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [NB-1:0]     s1_be
);
    localparam int HI_W = ADDR_W - 2;

    burst_st_e         st_q, st_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [1:0]        cnt_q, cnt_d;
    logic              nxt_vld, nxt_wr;
    logic [ADDR_W-1:0] nxt_addr;
    logic              chip_on;

    assign chip_on = !sel_a_n && sel_b && !sel_c_n;

    // State register and captured access slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
            s1_vld  <= 1'b0;
            s1_wr   <= 1'b0;
            s1_addr <= '0;
            s1_be   <= '0;
        end else begin
            st_q    <= st_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
            s1_vld  <= nxt_vld;
            s1_wr   <= nxt_wr;
            s1_addr <= nxt_addr;
            s1_be   <= be;
        end
    end

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        if (sleep) begin
            st_d = ST_IDLE;
        end else if (ld) begin
            if (chip_on) begin
                st_d   = wr ? ST_WR_BURST : ST_RD_BURST;
                base_d = addr;
                cnt_d  = 2'd0;
            end else begin
                st_d = ST_IDLE;
            end
        end else begin
            unique case (st_q)
                ST_IDLE:                  st_d = ST_IDLE;
                ST_RD_BURST, ST_WR_BURST: cnt_d = cnt_q + 2'd1;
                default:                  st_d = ST_IDLE;
            endcase
        end
    end

    // Output logic: the access captured on the next edge
    always_comb begin
        nxt_vld  = 1'b0;
        nxt_wr   = 1'b0;
        nxt_addr = addr;
        if (!sleep) begin
            if (ld) begin
                nxt_vld = chip_on;
                nxt_wr  = wr;
            end else begin
                unique case (st_q)
                    ST_RD_BURST: begin
                        nxt_vld  = 1'b1;
                        nxt_addr = {base_q[ADDR_W-1:2],
                                    beat_lo(base_q[1:0], cnt_q + 2'd1, ilv_order)};
                    end
                    ST_WR_BURST: begin
                        nxt_vld  = 1'b1;
                        nxt_wr   = 1'b1;
                        nxt_addr = {base_q[ADDR_W-1:2],
                                    beat_lo(base_q[1:0], cnt_q + 2'd1, ilv_order)};
                    end
                    default: nxt_vld = 1'b0;
                endcase
            end
        end
    end

    // R1: a deselecting load opens no access
    p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !sleep && !chip_on) |=> !s1_vld);

    // R11: sleep starts nothing
    p_sleep_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !s1_vld);

    // R7 / R8: a beat keeps the upper address bits and moves the low bits
    p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !sleep && st_q != ST_IDLE)
        |=> (s1_vld && $stable(s1_addr[ADDR_W-1:2])
             && s1_addr[1:0] != $past(s1_addr[1:0])));

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = base_q[ADDR_W-1:2];

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
    parameter int ADDR_W = 6,
    parameter int NB     = 4,
    parameter int BW     = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [NB-1:0]     wbe,
    input  logic [NB*BW-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [NB*BW-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BW-1:0] lane [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbe[b]) begin
                lane[waddr] <= wdata[b*BW +: BW];
            end
        end

        assign rdata[b*BW +: BW] = lane[raddr];
    end

endmodule

// File: rtl/lw_sram_late.sv
module lw_sram_late #(
    parameter int ADDR_W = 6,
    parameter int NB     = 4,
    parameter int BW     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_mode,
    input  logic              s1_vld,
    input  logic              s1_wr,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic [NB-1:0]     s1_be,
    input  logic [NB*BW-1:0]  wdata,
    input  logic [NB*BW-1:0]  arr_rd,
    output logic              cm_we,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [NB-1:0]     cm_be,
    output logic [NB*BW-1:0]  fwd_rd
);
    logic              s2_vld, s2_wr;
    logic [ADDR_W-1:0] s2_addr;
    logic [NB-1:0]     s2_be;
    logic              hit;

    // Second stage holds a pipelined write until its data arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld  <= 1'b0;
            s2_wr   <= 1'b0;
            s2_addr <= '0;
            s2_be   <= '0;
        end else begin
            s2_vld  <= s1_vld;
            s2_wr   <= s1_wr;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end

    // Flow-through commits from stage one, pipelined from stage two
    always_comb begin
        if (flow_mode) begin
            cm_we   = s1_vld && s1_wr;
            cm_addr = s1_addr;
            cm_be   = s1_be;
        end else begin
            cm_we   = s2_vld && s2_wr;
            cm_addr = s2_addr;
            cm_be   = s2_be;
        end
    end

    assign hit = !flow_mode && s2_vld && s2_wr && (s2_addr == s1_addr);

    for (genvar b = 0; b < NB; b++) begin : g_fwd
        assign fwd_rd[b*BW +: BW] = (hit && s2_be[b]) ? wdata[b*BW +: BW]
                                                      : arr_rd[b*BW +: BW];
    end

    // R4: a pipelined write commits on the edge after it leaves stage one
    p_late_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && s1_vld && s1_wr) |=> cm_we);

endmodule

// File: rtl/lw_sram_out.sv
module lw_sram_out #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flow_mode,
    input  logic          s1_rd,
    input  logic [DW-1:0] fwd_rd,
    input  logic          oe,
    input  logic          sleep,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe
);
    logic [DW-1:0] pipe_q;
    logic          pipe_vld_q;
    logic [DW-1:0] sel_d;
    logic          sel_v;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q     <= '0;
            pipe_vld_q <= 1'b0;
        end else begin
            pipe_q     <= fwd_rd;
            pipe_vld_q <= s1_rd;
        end
    end

    always_comb begin
        sel_d    = flow_mode ? fwd_rd : pipe_q;
        sel_v    = flow_mode ? s1_rd  : pipe_vld_q;
        rdata_oe = sel_v && oe && !sleep;
        rdata    = rdata_oe ? sel_d : '0;
    end

    // R10: output enable low silences the bus
    p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (!rdata_oe && rdata == '0));

    // R11: sleep silences the bus
    p_sleep_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!rdata_oe && rdata == '0));

    // R2: a pipelined read drives nothing in its own capture cycle
    p_pipe_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && !$past(s1_rd) && s1_rd) |-> !rdata_oe);

endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
    parameter int ADDR_W = 6,
    parameter int NB     = 4,
    parameter int BW     = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flow_mode,
    input  logic                ilv_order,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                ld,
    input  logic                wr,
    input  logic [NB-1:0]       be,
    input  logic [NB*BW-1:0]    wdata,
    input  logic                oe,
    input  logic                sleep,
    output logic [NB*BW-1:0]    rdata,
    output logic                rdata_oe
);
    localparam int DW = NB * BW;

    logic              s1_vld, s1_wr, s1_rd;
    logic [ADDR_W-1:0] s1_addr;
    logic [NB-1:0]     s1_be;
    logic              cm_we;
    logic [ADDR_W-1:0] cm_addr;
    logic [NB-1:0]     cm_be;
    logic [DW-1:0]     arr_rd, fwd_rd;

    assign s1_rd = s1_vld && !s1_wr;

    lw_sram_ctrl #(.ADDR_W(ADDR_W), .NB(NB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ilv_order(ilv_order), .addr(addr),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .ld(ld), .wr(wr), .be(be), .sleep(sleep),
        .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr), .s1_be(s1_be)
    );

    lw_sram_late #(.ADDR_W(ADDR_W), .NB(NB), .BW(BW)) u_late (
        .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode),
        .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr), .s1_be(s1_be),
        .wdata(wdata), .arr_rd(arr_rd),
        .cm_we(cm_we), .cm_addr(cm_addr), .cm_be(cm_be), .fwd_rd(fwd_rd)
    );

    lw_sram_array #(.ADDR_W(ADDR_W), .NB(NB), .BW(BW)) u_array (
        .clk(clk), .we(cm_we), .waddr(cm_addr), .wbe(cm_be), .wdata(wdata),
        .raddr(s1_addr), .rdata(arr_rd)
    );

    lw_sram_out #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .s1_rd(s1_rd),
        .fwd_rd(fwd_rd), .oe(oe), .sleep(sleep),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

endmodule

// File: tb/test_lw_sram.sv
module test_lw_sram;
    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          flow_mode = 0, ilv_order = 0;
    logic [AW-1:0] addr = '0;
    logic          sel_a_n = 1, sel_b = 0, sel_c_n = 1;
    logic          ld = 1, wr = 0;
    logic [3:0]    be = '0;
    logic [DW-1:0] wdata = '0;
    logic          oe = 1, sleep = 0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    lw_sram i_lw_sram (
        .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .ilv_order(ilv_order),
        .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .ld(ld), .wr(wr), .be(be), .wdata(wdata), .oe(oe), .sleep(sleep),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int at; logic [DW-1:0] d; string tag; } exp_t;
    exp_t           sb_q[$];
    logic [DW-1:0]  ref_mem [64];
    logic [DW-1:0]  wd_sched [int];
    int             total = 0, bad = 0;
    bit             done = 0;
    int             m_st = 0;
    logic [AW-1:0]  m_base = '0;
    logic [1:0]     m_cnt = '0;

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cyc %0d: actual=%h expected=%h", tag, cyc, act, expv);
        end
    endtask

    // Driver: one bus cycle, updates the bench model and the scoreboard
    task automatic step(input bit l, input bit w, input logic [AW-1:0] a,
                        input logic [3:0] b, input logic [DW-1:0] d,
                        input int sel, input bit sl, input string tag);
        int            e;
        bit            v;
        bit            isw;
        logic [AW-1:0] ea;
        @(negedge clk);
        e = cyc + 1;
        ld = l; wr = w; addr = a; be = b; sleep = sl;
        sel_a_n = (sel == 1); sel_b = (sel != 2); sel_c_n = (sel == 3);
        wdata = wd_sched.exists(e) ? wd_sched[e] : 36'hbadbadbad;
        v = 0; isw = 0; ea = a;
        if (sl) m_st = 0;
        else if (l) begin
            if (sel == 0) begin
                v = 1; isw = w; m_base = a; m_cnt = 0; m_st = w ? 2 : 1;
            end else m_st = 0;
        end else if (m_st != 0) begin
            m_cnt = m_cnt + 2'd1;
            ea = {m_base[AW-1:2], ilv_order ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
            v = 1; isw = (m_st == 2);
        end
        if (v && isw) begin
            for (int i = 0; i < 4; i++)
                if (b[i]) ref_mem[ea][i*9 +: 9] = d[i*9 +: 9];
            wd_sched[e + (flow_mode ? 1 : 2)] = d;
        end else if (v) begin
            exp_t it;
            it.at = e + (flow_mode ? 0 : 1);
            it.d = ref_mem[ea];
            it.tag = tag;
            sb_q.push_back(it);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 0, '0, '0, '0, 2, 0, "R1");
    endtask

    task automatic do_reset(input bit fm, input bit io);
        @(negedge clk);
        rst_n = 0; flow_mode = fm; ilv_order = io; ld = 1; sel_b = 0; sleep = 0; oe = 1;
        sb_q.delete(); wd_sched.delete(); m_st = 0;
        repeat (3) @(negedge clk);
        check(!rdata_oe && rdata == '0, "R12 reset", rdata, '0);
        rst_n = 1;
    endtask

    // Monitor: pops expected reads and checks empty slots
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && !done) begin
                while (sb_q.size() > 0 && sb_q[0].at < cyc) begin
                    exp_t it;
                    it = sb_q.pop_front();
                    check(0, {it.tag, " missed slot"}, rdata, it.d);
                end
                if (sb_q.size() > 0 && sb_q[0].at == cyc) begin
                    exp_t it;
                    logic [DW-1:0] ed;
                    bit            eo;
                    it = sb_q.pop_front();
                    eo = oe && !sleep;
                    ed = eo ? it.d : '0;
                    check(rdata_oe == eo && rdata == ed, it.tag, rdata, ed);
                end else begin
                    check(!rdata_oe && rdata == '0, "R12/R13 empty slot", rdata, '0);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            check(0, "R5 watchdog", '0, '1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        // ---------- pipelined, linear ----------
        do_reset(0, 0);
        step(0, 0, 6'd0, 4'hf, '0, 0, 0, "R13");            // advance while idle
        idle(2);
        for (int i = 0; i < 64; i++) step(1, 1, i[5:0], 4'hf, 36'h0 + i, 0, 0, "R12");
        step(1, 1, 6'd6, 4'hf, 36'h111111111, 0, 0, "R7");  // beats 6,7,4,5
        step(0, 1, 6'd0, 4'hf, 36'h222222222, 0, 0, "R7");
        step(0, 1, 6'd0, 4'hf, 36'h333333333, 0, 0, "R7");
        step(0, 1, 6'd0, 4'hf, 36'h444444444, 0, 0, "R7");
        step(1, 0, 6'd5, 4'hf, '0, 0, 0, "R7 R9 linear beat0"); // 5,6,7,4
        step(0, 0, 6'd0, 4'hf, '0, 0, 0, "R7 beat1");
        step(0, 0, 6'd0, 4'hf, '0, 0, 0, "R7 beat2");
        step(0, 0, 6'd0, 4'hf, '0, 0, 0, "R7 beat3");
        step(1, 1, 6'd20, 4'hf, 36'haaaaaaaaa, 0, 0, "R4");
        step(1, 0, 6'd6, 4'hf, '0, 0, 0, "R5 R2");
        step(1, 1, 6'd40, 4'hf, 36'h123456789, 0, 0, "R4");
        step(1, 0, 6'd20, 4'hf, '0, 0, 0, "R5 R4");
        step(1, 0, 6'd40, 4'hf, '0, 0, 0, "R5 R9");
        step(1, 1, 6'd20, 4'b0101, 36'h5a5a5a5a5, 0, 0, "R6");
        idle(1);
        step(1, 0, 6'd20, 4'hf, '0, 0, 0, "R6 byte merge");
        step(1, 1, 6'd30, 4'hf, 36'hccccccccc, 0, 0, "R9");
        step(1, 1, 6'd30, 4'b0011, 36'h0fedcba98, 0, 0, "R9");
        step(1, 0, 6'd30, 4'hf, '0, 0, 0, "R9 forward");
        step(1, 0, 6'd30, 4'hf, '0, 0, 0, "R9 after commit");
        step(1, 0, 6'd6, 4'hf, '0, 1, 0, "R1");
        step(1, 0, 6'd6, 4'hf, '0, 2, 0, "R1");
        step(1, 0, 6'd6, 4'hf, '0, 3, 0, "R1");
        step(0, 0, 6'd6, 4'hf, '0, 0, 0, "R1");
        step(1, 0, 6'd6, 4'hf, '0, 0, 0, "R10");
        oe = 0;
        step(1, 0, 6'd7, 4'hf, '0, 0, 0, "R10 oe off");
        step(1, 0, 6'd7, 4'hf, '0, 0, 0, "R10 oe off");
        idle(2);
        oe = 1;
        step(1, 0, 6'd7, 4'hf, '0, 0, 0, "R10 oe back");
        step(1, 0, 6'd4, 4'hf, '0, 0, 0, "R11 read into sleep");
        step(1, 0, 6'd6, 4'hf, '0, 0, 1, "R11");
        step(1, 1, 6'd6, 4'hf, 36'h999999999, 0, 1, "R11");
        step(0, 1, 6'd6, 4'hf, 36'h999999999, 0, 1, "R11");
        step(1, 0, 6'd6, 4'hf, '0, 0, 0, "R11 kept");
        step(1, 0, 6'd5, 4'hf, '0, 0, 0, "R11 kept");
        idle(4);
        // ---------- flow-through, interleaved ----------
        do_reset(1, 1);
        idle(1);
        step(1, 1, 6'd9, 4'hf, 36'h0f0f0f0f0, 0, 0, "R8");  // beats 9,8,11,10
        step(0, 1, 6'd0, 4'hf, 36'h0f1f1f1f1, 0, 0, "R8");
        step(0, 1, 6'd0, 4'hf, 36'h0f2f2f2f2, 0, 0, "R8");
        step(0, 1, 6'd0, 4'hf, 36'h0f3f3f3f3, 0, 0, "R8");
        step(1, 0, 6'd10, 4'hf, '0, 0, 0, "R8 R3 beat0");   // 10,11,8,9
        step(0, 0, 6'd0, 4'hf, '0, 0, 0, "R8 beat1");
        step(0, 0, 6'd0, 4'hf, '0, 0, 0, "R8 beat2");
        step(0, 0, 6'd0, 4'hf, '0, 0, 0, "R8 beat3");
        step(1, 1, 6'd50, 4'hf, 36'h7654321ab, 0, 0, "R4");
        step(1, 0, 6'd50, 4'hf, '0, 0, 0, "R3 R4 R5");
        step(1, 1, 6'd50, 4'b1000, 36'h1ffffffff, 0, 0, "R6");
        step(1, 0, 6'd50, 4'hf, '0, 0, 0, "R6 flow byte");
        step(1, 0, 6'd9, 4'hf, '0, 0, 0, "R3");
        idle(4);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule